// File: doc/BRIEF.md
# Channel Enable Command Registers

This block holds two per-channel enable vectors for a multi-channel transfer engine. One vector gates the channel service requests and the other gates the per-channel error interrupts. Software does not write either vector directly. It writes a 32-bit command word made of four byte-wide commands, each guarded by its own write strobe. The byte lanes are set-request, clear-request, set-error-enable and clear-error-enable. One bus write can therefore set and clear bits in both vectors at the same time.

Each command byte carries a skip flag in bit 7 and a 7-bit operand in bits 6:0. The operand names one channel, names every channel, or falls into a reserved range that does nothing. The command word reads back as zero. Each vector drives a read-only output and can also be read at its own status address. The other word addresses read zero.

Top module: `chan_enable_regs`

## Requirements
- R1: After reset both enable vectors are zero, on the outputs and at both status addresses.
- R2: A command byte with bit 7 = 1 has no effect, whatever bits 6:0 hold.
- R3: A command byte acts only when `wr_en` is 1, `wr_addr` is 0 (the command word) and the strobe of its lane is 1. Writes to any other address have no effect.
- R4: Lane 3 (bits 31:24) is set-request. An operand from 0 to NUM_CHAN-1 sets only that channel's bit in the request vector.
- R5: Lane 2 (bits 23:16) is clear-request. An operand from 0 to NUM_CHAN-1 clears only that channel's bit in the request vector.
- R6: An operand from 64 to 127 sets, or clears, every bit of the target vector.
- R7: Operands from NUM_CHAN to 63 (32 to 63 by default) are reserved and leave both vectors unchanged.
- R8: Lane 1 (bits 15:8) is set-error-enable and lane 0 (bits 7:0) is clear-error-enable. They act on the error vector with the same operand rules.
- R9: When a set and a clear reach the same bit of the same vector in one write, the bit ends up cleared.
- R10: Reading word address 0 (command) or word address 3 returns zero.
- R11: Word address 1 reads the request vector and word address 2 reads the error vector. Both match `req_en_o` and `err_en_o`.
- R12: A write changes the outputs at the first rising clock edge that samples it, and not before that edge.
- R13: Several lanes in one word apply together and act on both vectors independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write valid this cycle |
| wr_addr | input | ADDR_W (2) | Word address of the write |
| wr_data | input | 32 | Write data, four command bytes |
| wr_strb | input | 4 | Byte-lane write strobes |
| rd_addr | input | ADDR_W (2) | Word address for the combinational read |
| rd_data | output | 32 | Read data |
| req_en_o | output | NUM_CHAN (32) | Request enable vector |
| err_en_o | output | NUM_CHAN (32) | Error-interrupt enable vector |

## Verification
The stimulus covers single-channel operands at both ends of the index range (0 and 31), the all-channel operands 0x40 and 0x7F, and reserved operands 0x20 and 0x3F. The single and all cases separate the index decode from the broadcast decode. The reserved cases show that the range check does not fall back to either of them. Skip-flagged bytes, cleared strobes and writes to status addresses each carry otherwise valid operands, so any leak into the vectors shows up. Words that pair a set with a clear of the same bit, and words that mix lanes across both vectors, confirm the priority between lanes and that the two vectors stay independent. The outputs are also sampled before the clock edge, which checks that an update lands exactly one edge after the write.

// File: rtl/chen_pkg.sv
package chen_pkg;

   localparam int LANES    = 4;
   localparam int BYTE_W   = 8;
   localparam int OPER_W   = 7;

   // word addresses
   localparam int ADDR_CMD      = 0;
   localparam int ADDR_REQ_STAT = 1;
   localparam int ADDR_ERR_STAT = 2;

   // byte lanes of the command word
   typedef enum int {
      LANE_CLR_ERR = 0,
      LANE_SET_ERR = 1,
      LANE_CLR_REQ = 2,
      LANE_SET_REQ = 3
   } lane_e;

   typedef struct packed {
      logic             skip;
      logic [OPER_W-1:0] oper;
   } cmd_byte_t;

   function automatic cmd_byte_t to_cmd(input logic [BYTE_W-1:0] b);
      cmd_byte_t c;
      c.skip = b[BYTE_W-1];
      c.oper = b[OPER_W-1:0];
      return c;
   endfunction

   function automatic logic is_broadcast(input logic [OPER_W-1:0] oper);
      return oper[OPER_W-1];
   endfunction

endpackage

// File: rtl/chen_cmd_decode.sv
module chen_cmd_decode
   import chen_pkg::*;
#(
   parameter int NUM_CHAN = 32,
   localparam int IDX_W   = $clog2(NUM_CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lane_en,
   input  logic [BYTE_W-1:0]   cmd_byte,
   output logic [NUM_CHAN-1:0] hit_mask
);

   cmd_byte_t cmd;
   logic      in_index;
   logic      in_bcast;

   assign cmd      = to_cmd(cmd_byte);
   assign in_index = (cmd.oper < OPER_W'(NUM_CHAN));
   assign in_bcast = is_broadcast(cmd.oper);

   always_comb begin
      hit_mask = '0;
      if (lane_en && !cmd.skip) begin
         if (in_index) begin
            hit_mask[cmd.oper[IDX_W-1:0]] = 1'b1;
         end else if (in_bcast) begin
            hit_mask = '1;
         end
      end
   end

   // R4/R5: a single-channel operand touches exactly one bit
   a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en && !cmd_byte[7] && (cmd_byte[6:0] < 7'(NUM_CHAN)))
         |-> ($countones(hit_mask) == 1));

   // R7: reserved operands select nothing
   a_r7_reserved_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_byte[6:0] >= 7'(NUM_CHAN)) && !cmd_byte[6]) |-> (hit_mask == '0));

endmodule

// File: rtl/chen_en_vec.sv
module chen_en_vec #(
   parameter int NUM_CHAN = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] set_mask,
   input  logic [NUM_CHAN-1:0] clr_mask,
   output logic [NUM_CHAN-1:0] vec_q
);

   logic [NUM_CHAN-1:0] vec_d;

   // clear has priority over set on the same bit
   always_comb begin
      vec_d = (vec_q | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
      end else begin
         vec_q <= vec_d;
      end
   end

   // R9: any bit hit by a clear is zero after the edge
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask) |=> ((vec_q & $past(clr_mask)) == '0));

   // R6: broadcast set with no clear fills the vector
   a_r6_set_all: assert property (@(posedge clk) disable iff (!rst_n)
      ((&set_mask) && (clr_mask == '0)) |=> (&vec_q));

   // R12: without commands the vector holds
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_mask == '0) && (clr_mask == '0)) |=> $stable(vec_q));

endmodule

// File: rtl/chen_read_mux.sv
module chen_read_mux
   import chen_pkg::*;
#(
   parameter int NUM_CHAN = 32,
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 32
) (
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [NUM_CHAN-1:0] req_vec,
   input  logic [NUM_CHAN-1:0] err_vec,
   output logic [DATA_W-1:0]   rd_data
);

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_REQ_STAT)) begin
         rd_data = DATA_W'(req_vec);
      end else if (rd_addr == ADDR_W'(ADDR_ERR_STAT)) begin
         rd_data = DATA_W'(err_vec);
      end
   end

endmodule

// File: rtl/chan_enable_regs.sv
module chan_enable_regs
   import chen_pkg::*;
#(
   parameter int NUM_CHAN = 32,
   parameter int ADDR_W   = 2,
   localparam int DATA_W  = LANES * BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [LANES-1:0]    wr_strb,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_CHAN-1:0] req_en_o,
   output logic [NUM_CHAN-1:0] err_en_o
);

   if (NUM_CHAN < 2 || NUM_CHAN > 32) begin : g_bad_chan
      $error("NUM_CHAN must lie in 2..32");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic                cmd_wr;
   logic [NUM_CHAN-1:0] lane_mask [LANES];

   assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      chen_cmd_decode #(.NUM_CHAN(NUM_CHAN)) u_dec (
         .clk      (clk),
         .rst_n    (rst_n),
         .lane_en  (cmd_wr && wr_strb[k]),
         .cmd_byte (wr_data[k*BYTE_W +: BYTE_W]),
         .hit_mask (lane_mask[k])
      );
   end

   chen_en_vec #(.NUM_CHAN(NUM_CHAN)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (lane_mask[LANE_SET_REQ]),
      .clr_mask (lane_mask[LANE_CLR_REQ]),
      .vec_q    (req_en_o)
   );

   chen_en_vec #(.NUM_CHAN(NUM_CHAN)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (lane_mask[LANE_SET_ERR]),
      .clr_mask (lane_mask[LANE_CLR_ERR]),
      .vec_q    (err_en_o)
   );

   chen_read_mux #(
      .NUM_CHAN (NUM_CHAN),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_rd (
      .rd_addr (rd_addr),
      .req_vec (req_en_o),
      .err_vec (err_en_o),
      .rd_data (rd_data)
   );

   // R3: a write with no strobe, or to another address, changes nothing
   a_r3_inactive_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((wr_strb == '0) || (wr_addr != '0)))
         |=> ($stable(req_en_o) && $stable(err_en_o)));

   // R2: all four bytes skip-flagged leaves both vectors alone
   a_r2_all_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31] && wr_data[23] && wr_data[15] && wr_data[7])
         |=> ($stable(req_en_o) && $stable(err_en_o)));

   // R10: the command word reads zero
   a_r10_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == '0) |-> (rd_data == '0));

   // R11: status addresses mirror the outputs
   a_r11_req_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(1)) |-> (rd_data == DATA_W'(req_en_o)));

endmodule

// File: tb/test_chan_enable_regs.sv
module test_chan_enable_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_strb = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] req_en_o;
   logic [31:0] err_en_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] m_req = '0;
   logic [31:0] m_err = '0;

   logic [31:0] q_req [$];
   logic [31:0] q_err [$];
   string       q_tag [$];

   always #5 clk = ~clk;

   chan_enable_regs i_chan_enable_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_strb  (wr_strb),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .req_en_o (req_en_o),
      .err_en_o (err_en_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lane_mask(input logic [7:0] b, input bit act);
      if (!act || b[7]) return 32'h0;
      if (b[6:0] < 7'd32) return 32'h1 << b[4:0];
      if (b[6]) return 32'hFFFF_FFFF;
      return 32'h0;
   endfunction

   // driver: apply one write, predict, push expected item
   task automatic cmd_write(input logic [1:0] addr, input logic [31:0] data,
                            input logic [3:0] strb, input string tag);
      logic [31:0] m3, m2, m1, m0, old_req, old_err;
      bit          cmd;
      cmd = (addr == 2'd0);
      m3 = lane_mask(data[31:24], cmd && strb[3]);
      m2 = lane_mask(data[23:16], cmd && strb[2]);
      m1 = lane_mask(data[15:8],  cmd && strb[1]);
      m0 = lane_mask(data[7:0],   cmd && strb[0]);
      old_req = m_req;
      old_err = m_err;
      m_req = (m_req | m3) & ~m2;
      m_err = (m_err | m1) & ~m0;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data; wr_strb = strb;
      #1;
      check({"R12 pre-edge req ", tag}, req_en_o, old_req);
      check({"R12 pre-edge err ", tag}, err_en_o, old_err);
      @(posedge clk);
      #1;
      wr_en = 1'b0; wr_strb = '0;
      q_req.push_back(m_req);
      q_err.push_back(m_err);
      q_tag.push_back(tag);
   endtask

   // monitor: compare outputs with the queued expectation
   always @(negedge clk) begin
      if (q_req.size() != 0) begin
         logic [31:0] er, ee;
         string t;
         er = q_req.pop_front();
         ee = q_err.pop_front();
         t  = q_tag.pop_front();
         check({t, " req"}, req_en_o, er);
         check({t, " err"}, err_en_o, ee);
      end
   end

   task automatic check_rd(input logic [1:0] addr, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr = addr;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset req_en_o", req_en_o, 32'h0);
      check("R1 reset err_en_o", err_en_o, 32'h0);
      check_rd(2'd1, 32'h0, "R1 reset req status");
      check_rd(2'd2, 32'h0, "R1 reset err status");

      cmd_write(2'd0, 32'h0500_0000, 4'b1000, "R4 set req ch5");
      cmd_write(2'd0, 32'h1F00_0000, 4'b1000, "R4 set req ch31");
      cmd_write(2'd0, 32'h0000_0000, 4'b0010, "R8 set err ch0");
      cmd_write(2'd0, 32'h0000_1F00, 4'b0010, "R8 set err ch31");
      cmd_write(2'd0, 32'h0005_0000, 4'b0100, "R5 clear req ch5");
      cmd_write(2'd0, 32'h201F_3F00, 4'b1010, "R7 reserved operands");
      cmd_write(2'd0, 32'h8585_8585, 4'b1111, "R2 skip flag set");
      cmd_write(2'd0, 32'h0700_0900, 4'b0000, "R3 no strobe");
      cmd_write(2'd1, 32'h0800_0A00, 4'b1111, "R3 status address write");
      cmd_write(2'd2, 32'h4000_4000, 4'b1111, "R3 err status address write");
      cmd_write(2'd0, 32'h4000_0000, 4'b1000, "R6 set all req");
      cmd_write(2'd0, 32'h0000_7F00, 4'b0010, "R6 set all err 0x7F");
      cmd_write(2'd0, 32'h0000_001F, 4'b0001, "R8 clear err ch31");
      cmd_write(2'd0, 32'h0707_0000, 4'b1100, "R9 set and clear ch7");
      cmd_write(2'd0, 32'h0000_0A40, 4'b0011, "R9 set err vs clear all");
      cmd_write(2'd0, 32'h0340_0A80, 4'b1111, "R13 multi-lane word");
      cmd_write(2'd0, 32'h0C80_1100, 4'b1011, "R13 mixed lanes");
      repeat (2) @(negedge clk);

      check_rd(2'd1, m_req, "R11 req status read");
      check_rd(2'd2, m_err, "R11 err status read");
      check_rd(2'd0, 32'h0, "R10 command word read");
      check_rd(2'd3, 32'h0, "R10 unused address read");
      check("R11 req output matches", req_en_o, m_req);
      check("R11 err output matches", err_en_o, m_err);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule